// File: doc/BRIEF.md
# Sleep-Time Interrupt Recorder and Replayer

This block sits between a group of external interrupt lines and a parent interrupt controller. Each line carries its own mask, sense (level or edge) and polarity setting. Every line has a pending bit that is set whenever the line's configured event is seen, including while the block's enable bit is clear. While the system sleeps, the lines are recorded in this way. On wake, software commands a flush, and the block sends the recorded events to the parent controller as one-cycle pulses, so interrupts that arrived during sleep are not lost.

A 32-bit register bus with combinational read data gives access to the block. There are write-one-to-set and write-one-to-clear banks for mask, sense and polarity, a per-line acknowledge bank, and a control word. A small state machine carries out the replay. It has three states: `ST_IDLE`, which waits for flush; `ST_SCAN`, which visits one line per cycle in ascending order; and `ST_DONE`, which lasts one cycle and clears the flush bit. The transitions are: IDLE to SCAN when flush is set; SCAN to SCAN while the line index is below the last line; SCAN to DONE on the last line; and DONE to IDLE unconditionally.

Top module: `irq_rec_top`

## Requirements
- R1: After reset, the mask and sense banks read 0. The polarity bank reads all ones. The control word and the acknowledge bank read 0, and every `irq_out` bit is 0.
- R2: Line n maps to bit n mod 32 of the word at bank base + 4*(n div 32). The bank bases are: acknowledge 0x40, mask set 0xC0, mask clear 0x100, sense set 0x180, sense clear 0x1C0, polarity set 0x240, polarity clear 0x280. The control word is at 0x300, with bit 0 enable, bit 1 edge-only mode and bit 2 flush.
- R3: A write to a set bank sets the bits written as 1. A write to a clear bank clears the bits written as 1. Bits written as 0 keep their value. Both the set address and the clear address of a bank read back its current value.
- R4: With sense 0 (edge), a line records a rising edge when its polarity is 1 and a falling edge when its polarity is 0. Recording happens after a two-flop synchronizer. An edge of the opposite direction is not recorded.
- R5: With sense 1 (level), a line records on every cycle its synchronized input equals its polarity bit.
- R6: While the control word's bit 1 is set, level events are not recorded, and edge events still are.
- R7: Recording takes place whatever the value of the enable bit or the line's mask bit.
- R8: Reads of the acknowledge bank return the pending bits. Writing 1 to a line's acknowledge bit clears its pending bit, except that an event on the same line in the same cycle keeps it set.
- R9: Writing 1 to control bit 2 starts a replay. Lines are scanned in ascending order. Each pending, unmasked line gets exactly one one-cycle pulse on `irq_out` at its polarity level, and its pending bit is cleared. Outside a pulse, `irq_out` sits at the inverse of the polarity.
- R10: Masked pending lines are not pulsed during replay and stay pending.
- R11: The flush bit reads 1 while the replay runs and clears itself when the scan completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | NUM_LINES | External interrupt lines (asynchronous) |
| irq_out | output | NUM_LINES | Signals to the parent controller |

## Verification
An acknowledge write and a fresh event on the same line can land in the same clock edge. The bench provokes this by holding a level-sensitive line at its active level while it acknowledges that line; the pending bit must still read 1 afterwards. It then drops the line and acknowledges again, expecting 0. Replay and recording can also coincide, and the flush test judges this by counting pulses per line and by reading the pending bank after the scan.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} rp_state_t;

    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_MSET = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFF_MCLR = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_SSET = 12'h180;
    localparam logic [ADDR_W-1:0] OFF_SCLR = 12'h1C0;
    localparam logic [ADDR_W-1:0] OFF_PSET = 12'h240;
    localparam logic [ADDR_W-1:0] OFF_PCLR = 12'h280;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h300;
endpackage

// File: rtl/irq_rec_sync.sv
module irq_rec_sync #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= async_i[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign cur_o[i]  = s2_q;
        assign prev_o[i] = s3_q;
    end
endmodule

// File: rtl/irq_rec_capture.sv
module irq_rec_capture #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] pol_i,
    input  logic         edge_only_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] replay_clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] edge_ev, lvl_ev, evt, pend_q;

    always_comb begin
        edge_ev = (pol_i & cur_i & ~prev_i) | (~pol_i & ~cur_i & prev_i);
        lvl_ev  = ~(cur_i ^ pol_i) & {N{~edge_only_i}};
        evt     = (sense_i & lvl_ev) | (~sense_i & edge_ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_i & ~replay_clr_i) | evt;
    end

    assign pend_o = pend_q;

    // R8: an acknowledge with no concurrent event leaves the bit clear
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        |(ack_i & ~evt) |=> ((pend_q & $past(ack_i & ~evt)) == '0));
    // R7: every detected event is recorded on the next edge
    a_r7_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        |evt |=> ((pend_q & $past(evt)) == $past(evt)));
    // R6: level-only lines never record in edge-only mode
    a_r6_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_only_i && $stable(edge_only_i)) |-> ((evt & sense_i) == '0));
endmodule

// File: rtl/irq_rec_replay.sv
module irq_rec_replay
    import irq_rec_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] pulse_o,
    output logic [N-1:0] clr_o,
    output logic         done_o
);
    localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    rp_state_t       state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic [N-1:0]    pulse_q, pulse_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pulse_q <= pulse_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pulse_d = '0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (flush_i) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                pulse_d[idx_q] = pend_i[idx_q] & ~mask_i[idx_q];
                if (idx_q == LAST) state_d = ST_DONE;
                else               idx_d   = idx_q + 1'b1;
            end
            ST_DONE: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pulse_o = pulse_q;
    assign clr_o   = pulse_d;

    // R9: at most one line pulses at a time, only right after a scan cycle
    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));
    a_r9_pulse_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_q) |-> $past(state_q == ST_SCAN));
    a_r9_pulse_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_q) |-> ((pulse_q & ~$past(pend_i)) == '0));
    // R10: masked lines are never pulsed
    a_r10_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_q) |-> ((pulse_q & $past(mask_i)) == '0));
endmodule

// File: rtl/irq_rec_top.sv
module irq_rec_top
    import irq_rec_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    localparam int unsigned NW = (NUM_LINES + 31) / 32;
    localparam int unsigned NP = NW * 32;

    logic [NP-1:0] mask_w, sense_w, pol_w, ack_w, pend_w;
    logic [NUM_LINES-1:0] cur, prev, pend, pulse, rclr;
    logic en_q, eo_q, flush_q, done;
    logic ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam logic [11:0] WO = 12'(4 * w);
        logic [31:0] m_q, s_q, p_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '0;
                s_q <= '0;
                p_q <= '1;
            end else if (bus_wr) begin
                if (bus_addr == OFF_MSET + WO) m_q <= m_q | bus_wdata;
                if (bus_addr == OFF_MCLR + WO) m_q <= m_q & ~bus_wdata;
                if (bus_addr == OFF_SSET + WO) s_q <= s_q | bus_wdata;
                if (bus_addr == OFF_SCLR + WO) s_q <= s_q & ~bus_wdata;
                if (bus_addr == OFF_PSET + WO) p_q <= p_q | bus_wdata;
                if (bus_addr == OFF_PCLR + WO) p_q <= p_q & ~bus_wdata;
            end
        end
        assign mask_w[w*32 +: 32]  = m_q;
        assign sense_w[w*32 +: 32] = s_q;
        assign pol_w[w*32 +: 32]   = p_q;
        assign ack_w[w*32 +: 32]   = (bus_wr && bus_addr == OFF_ACK + WO) ? bus_wdata : '0;
    end

    if (NP > NUM_LINES) begin : g_pad
        assign pend_w = {{(NP-NUM_LINES){1'b0}}, pend};
    end else begin : g_nopad
        assign pend_w = pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            eo_q    <= 1'b0;
            flush_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q    <= bus_wdata[0];
            eo_q    <= bus_wdata[1];
            flush_q <= (flush_q & ~done) | bus_wdata[2];
        end else if (done) begin
            flush_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == OFF_ACK + 12'(4*w))
                bus_rdata = pend_w[w*32 +: 32];
            if (bus_addr == OFF_MSET + 12'(4*w) || bus_addr == OFF_MCLR + 12'(4*w))
                bus_rdata = mask_w[w*32 +: 32];
            if (bus_addr == OFF_SSET + 12'(4*w) || bus_addr == OFF_SCLR + 12'(4*w))
                bus_rdata = sense_w[w*32 +: 32];
            if (bus_addr == OFF_PSET + 12'(4*w) || bus_addr == OFF_PCLR + 12'(4*w))
                bus_rdata = pol_w[w*32 +: 32];
        end
        if (bus_addr == OFF_CTRL) bus_rdata = {29'b0, flush_q, eo_q, en_q};
    end

    irq_rec_sync #(.N(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_in), .cur_o(cur), .prev_o(prev)
    );

    irq_rec_capture #(.N(NUM_LINES)) u_cap (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .sense_i(sense_w[NUM_LINES-1:0]), .pol_i(pol_w[NUM_LINES-1:0]),
        .edge_only_i(eo_q), .ack_i(ack_w[NUM_LINES-1:0]),
        .replay_clr_i(rclr), .pend_o(pend)
    );

    irq_rec_replay #(.N(NUM_LINES)) u_rep (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_q), .pend_i(pend),
        .mask_i(mask_w[NUM_LINES-1:0]), .pulse_o(pulse), .clr_o(rclr),
        .done_o(done)
    );

    assign irq_out = ~(pol_w[NUM_LINES-1:0] ^ pulse);

    // R11: the scan's end clears the flush bit
    a_r11_flush_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctrl_wr) |=> !flush_q);
    // R11: a pulse is only seen while a flush is in progress
    a_r11_pulse_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> flush_q);
endmodule

// File: tb/irq_rec_top_tb_top.sv
`timescale 1ns/1ps
module irq_rec_top_tb_top;
    localparam int N = 64;
    localparam logic [11:0] A_ACK = 12'h040, A_MSET = 12'h0C0, A_MCLR = 12'h100,
        A_SSET = 12'h180, A_SCLR = 12'h1C0, A_PSET = 12'h240, A_PCLR = 12'h280,
        A_CTRL = 12'h300;

    logic clk = 0, rst_n = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] irq_in = '0, irq_out;
    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_rec_top #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    // {line[6:0], sense, pol, edge_only, start, end, expected}
    localparam logic [12:0] VEC [0:7] = '{
        {7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {7'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {7'd33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {7'd33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {7'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {7'd5,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {7'd63, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {7'd63, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        irq_in = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R1 reset state
        rd(A_MSET, d);           check("R1 mask", d, 0);
        rd(A_SCLR + 12'd4, d);   check("R1 sense", d, 0);
        rd(A_PSET + 12'd4, d);   check("R1 pol", d, 32'hFFFF_FFFF);
        rd(A_CTRL, d);           check("R1 ctrl", d, 0);
        rd(A_ACK, d);            check("R1 pending", d, 0);
        check("R1 irq_out", irq_out, 0);

        // R3 set/clear banks
        wr(A_MSET, 32'h5);   rd(A_MSET, d); check("R3 set", d, 32'h5);
        wr(A_MSET, 32'h2);   rd(A_MCLR, d); check("R3 set keeps zeros", d, 32'h7);
        wr(A_MCLR, 32'h4);   rd(A_MSET, d); check("R3 clear", d, 32'h3);
        wr(A_MCLR, 32'hFFFF_FFFF);

        // R2 R4 R5 R6 R7 table walk (enable stays 0)
        for (int k = 0; k < 8; k++) begin
            logic [12:0] v;
            int ln;
            logic [11:0] wo;
            logic [31:0] bm;
            v  = VEC[k];
            ln = int'(v[12:6]);
            wo = 12'(4 * (ln / 32));
            bm = 32'h1 << (ln % 32);
            wr(v[5] ? A_SSET + wo : A_SCLR + wo, bm);
            wr(v[4] ? A_PSET + wo : A_PCLR + wo, bm);
            wr(A_CTRL, {30'b0, v[3], 1'b0});
            irq_in[ln] = v[2];
            repeat (6) @(negedge clk);
            wr(A_ACK + wo, bm);
            irq_in[ln] = v[1];
            repeat (6) @(negedge clk);
            rd(A_ACK + wo, d);
            check($sformatf("R2 R4 R5 R6 R7 vec%0d line%0d", k, ln), 64'(d[ln % 32]), 64'(v[0]));
        end

        // R8 same-cycle ack and event: event wins
        do_reset();
        wr(A_SSET, 32'h80);
        irq_in[7] = 1;
        repeat (6) @(negedge clk);
        wr(A_ACK, 32'h80);
        rd(A_ACK, d); check("R8 event beats ack", 64'(d[7]), 1);
        irq_in[7] = 0;
        repeat (6) @(negedge clk);
        wr(A_ACK, 32'h80);
        rd(A_ACK, d); check("R8 ack clears", 64'(d[7]), 0);

        // R9 R10 R11 flush replay
        do_reset();
        wr(A_MSET, 32'h400);          // mask line 10
        wr(A_PCLR + 12'd4, 32'h100);  // line 40 falling, active low
        check("R9 idle level", irq_out, 64'h0000_0100_0000_0000);
        irq_in[3] = 1; irq_in[10] = 1; irq_in[40] = 1;
        repeat (6) @(negedge clk);
        irq_in[3] = 0; irq_in[10] = 0; irq_in[40] = 0;
        repeat (6) @(negedge clk);
        rd(A_ACK, d);         check("R7 masked recorded", d, 32'h408);
        rd(A_ACK + 12'd4, d); check("R4 falling recorded", d, 32'h100);
        begin
            int c3, c40, cother, t3, t40;
            bit saw_flush;
            c3 = 0; c40 = 0; cother = 0; t3 = -1; t40 = -1; saw_flush = 0;
            wr(A_CTRL, 32'h4);
            bus_addr = A_CTRL;
            for (int t = 0; t < 120; t++) begin
                #1;
                if (bus_rdata[2]) saw_flush = 1;
                if (irq_out[3] == 1)  begin c3++;  if (t3 < 0) t3 = t; end
                if (irq_out[40] == 0) begin c40++; if (t40 < 0) t40 = t; end
                for (int i = 0; i < N; i++)
                    if (i != 3 && i != 40 && irq_out[i]) cother++;
                @(negedge clk);
            end
            check("R9 line3 one pulse", 64'(c3), 1);
            check("R9 line40 one active-low pulse", 64'(c40), 1);
            check("R10 no other pulses", 64'(cother), 0);
            check("R9 ascending order", 64'(t3 < t40), 1);
            check("R11 flush seen busy", 64'(saw_flush), 1);
        end
        rd(A_CTRL, d);        check("R11 flush self-clears", d, 0);
        rd(A_ACK, d);         check("R10 masked stays pending", d, 32'h400);
        rd(A_ACK + 12'd4, d); check("R9 replayed cleared", d, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule